// File: doc/BRIEF.md
# Low-Power SDRAM Power-Up and Deep Power-Down Sequencer

This block sits on the controller side of a low-power SDRAM. It owns the command pins (clock enable, chip select, row strobe, column strobe, write enable, bank select and address) from reset until the memory may accept normal traffic. It waits out the power-up settling time with NOP on the pins. It then closes all banks, runs a burst of auto-refresh commands and writes the mode and extended-mode registers from two programmable input words. After that it raises `ready`. Every delay is a parameter counted in clock cycles.

Once the memory is ready, a request can place it in deep power-down. The sequencer closes open rows first when the normal controller reports that any bank is open. It then drops clock enable in the same cycle as the deep power-down command. The array loses its contents in that mode. An exit request therefore raises clock enable and replays the complete initialization sequence before `ready` returns. A request that arrives while a sequence is still running is held and acted on when that sequence finishes. A request that makes no sense in the current phase is dropped.

Top module: `lpsdram_pwr_seq`

## Requirements
- R1: Reset sets clock enable high, the command to NOP (csN=0, rasN=1, casN=1, weN=1) and `ready` low. After reset is released, NOP holds for exactly INIT_WAIT cycles before the first command, which appears on pin cycle INIT_WAIT+1 counted from the first clock edge after release.
- R2: The first command of each initialization is precharge-all: csN=0, rasN=0, casN=1, weN=0, with address 0x400 (bit 10 high, all other bits low) and bank 00.
- R3: REF_COUNT auto-refresh commands follow (csN=0, rasN=0, casN=0, weN=1). The first comes T_RP cycles after the precharge, and each later command comes T_RC cycles after the refresh before it.
- R4: A mode register write (all four strobes low, bank 00, address = `modeVal`) comes T_RC cycles after the last refresh. An extended mode write (bank 10, address = `extModeVal`) comes T_MRD cycles after it. Both use the input words as they stand when the write is issued, and the cycle after either write is never a command.
- R5: `ready` rises exactly T_MRD cycles after the extended mode write. While `ready` is high, the pins carry NOP with clock enable high.
- R6: An entry request while ready, with `bankOpen` low, produces the deep power-down command three cycles after the request cycle. That command is csN=0, rasN=1, casN=1, weN=0. Clock enable falls and `ready` falls in that same cycle.
- R7: With `bankOpen` high, the entry request first produces a precharge-all three cycles after the request, with `ready` low. The deep power-down command follows T_RP cycles later.
- R8: In deep power-down, clock enable stays low and the pins carry deselect (csN=1) until an exit request.
- R9: An exit request raises clock enable with NOP three cycles after the request cycle. NOP then holds for INIT_WAIT cycles, and the full sequence of R2 to R5 repeats.
- R10: An entry request made during initialization is held. The deep power-down command then follows one cycle after `ready` rises.
- R11: An exit request made while the pre-entry precharge is pending is held. Clock enable rises two cycles after the deep power-down command.
- R12: An exit request while ready and an entry request while in deep power-down are dropped. No pin activity follows, and `ready` stays as it was, including after a later exit and reinitialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enterReq | input | 1 | Request to enter deep power-down |
| exitReq | input | 1 | Request to leave deep power-down |
| bankOpen | input | 1 | Normal controller has at least one row open |
| modeVal | input | ADDR_W | Address word written by the mode register write |
| extModeVal | input | ADDR_W | Address word written by the extended mode write |
| cke | output | 1 | Clock enable to the memory |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank select |
| addr | output | ADDR_W | Address bus |
| ready | output | 1 | Initialization complete; normal commands allowed |

## Verification
Every pin output is one register stage behind the state machine. A request made in cycle c therefore shows on the pins at c+3, and each later command lands exactly its parameter gap after the command before it. The bench encodes these offsets when it queues each expected pin event with its absolute cycle number. The monitor samples on the falling edge and matches the pin word, bank, address and cycle of every command, clock-enable change and `ready` change against the queue head. An unexpected event or a late one counts as a miss. That is how ignored requests and the idle NOP gaps between commands are checked.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;

  localparam int AP_BIT = 10;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_DESEL,
    CMD_PALL,
    CMD_AREF,
    CMD_MRS,
    CMD_EMRS,
    CMD_DPD
  } cmd_e;

  typedef enum logic [1:0] {
    WT_INIT,
    WT_RP,
    WT_RC,
    WT_MRD
  } wait_e;

  typedef struct packed {
    cmd_e  cmd;
    logic  ckeOn;
    logic  rdyOn;
    logic  cntLoad;
    wait_e cntSel;
    logic  refInc;
    logic  refClr;
  } strobe_t;

endpackage

// File: rtl/lpseq_ctrl.sv
module lpseq_ctrl
  import lpseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enterReq,
  input  logic    exitReq,
  input  logic    bankOpen,
  input  logic    cntZero,
  input  logic    refLast,
  output strobe_t stb
);

  typedef enum logic [3:0] {
    ST_PWR_WAIT,
    ST_PALL,
    ST_PALL_W,
    ST_REF,
    ST_REF_W,
    ST_MRS,
    ST_MRS_W,
    ST_EMRS,
    ST_EMRS_W,
    ST_READY,
    ST_DPD_PRE,
    ST_DPD_PRE_W,
    ST_DPD_ENTRY,
    ST_DPD
  } state_e;

  state_e state, stateNext;
  logic   enterPend, exitPend;
  logic   inDpdPath;
  logic   enterTake, exitTake;

  assign inDpdPath = (state == ST_DPD_PRE) || (state == ST_DPD_PRE_W) ||
                     (state == ST_DPD_ENTRY) || (state == ST_DPD);
  assign enterTake = (state == ST_READY) && enterPend;
  assign exitTake  = (state == ST_DPD) && exitPend;

  // request holding: accepted only in phases where they mean something
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enterPend <= 1'b0;
      exitPend  <= 1'b0;
    end else begin
      if (enterTake)                     enterPend <= 1'b0;
      else if (enterReq && !inDpdPath)   enterPend <= 1'b1;
      if (exitTake)                      exitPend  <= 1'b0;
      else if (exitReq && inDpdPath)     exitPend  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PWR_WAIT;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    stb.cmd     = CMD_NOP;
    stb.ckeOn   = 1'b1;
    stb.rdyOn   = 1'b0;
    stb.cntLoad = 1'b0;
    stb.cntSel  = WT_RP;
    stb.refInc  = 1'b0;
    stb.refClr  = 1'b0;
    unique case (state)
      ST_PWR_WAIT: if (cntZero) stateNext = ST_PALL;
      ST_PALL: begin
        stb.cmd     = CMD_PALL;
        stb.cntLoad = 1'b1;
        stb.cntSel  = WT_RP;
        stb.refClr  = 1'b1;
        stateNext   = ST_PALL_W;
      end
      ST_PALL_W: if (cntZero) stateNext = ST_REF;
      ST_REF: begin
        stb.cmd     = CMD_AREF;
        stb.cntLoad = 1'b1;
        stb.cntSel  = WT_RC;
        stb.refInc  = 1'b1;
        stateNext   = ST_REF_W;
      end
      ST_REF_W: if (cntZero) stateNext = refLast ? ST_MRS : ST_REF;
      ST_MRS: begin
        stb.cmd     = CMD_MRS;
        stb.cntLoad = 1'b1;
        stb.cntSel  = WT_MRD;
        stateNext   = ST_MRS_W;
      end
      ST_MRS_W: if (cntZero) stateNext = ST_EMRS;
      ST_EMRS: begin
        stb.cmd     = CMD_EMRS;
        stb.cntLoad = 1'b1;
        stb.cntSel  = WT_MRD;
        stateNext   = ST_EMRS_W;
      end
      ST_EMRS_W: if (cntZero) stateNext = ST_READY;
      ST_READY: begin
        stb.rdyOn = 1'b1;
        if (enterPend) stateNext = bankOpen ? ST_DPD_PRE : ST_DPD_ENTRY;
      end
      ST_DPD_PRE: begin
        stb.cmd     = CMD_PALL;
        stb.cntLoad = 1'b1;
        stb.cntSel  = WT_RP;
        stateNext   = ST_DPD_PRE_W;
      end
      ST_DPD_PRE_W: if (cntZero) stateNext = ST_DPD_ENTRY;
      ST_DPD_ENTRY: begin
        stb.cmd   = CMD_DPD;
        stb.ckeOn = 1'b0;
        stateNext = ST_DPD;
      end
      ST_DPD: begin
        stb.cmd   = CMD_DESEL;
        stb.ckeOn = 1'b0;
        if (exitPend) begin
          stb.cntLoad = 1'b1;
          stb.cntSel  = WT_INIT;
          stateNext   = ST_PWR_WAIT;
        end
      end
      default: stateNext = ST_PWR_WAIT;
    endcase
  end

endmodule

// File: rtl/lpseq_dpath.sv
module lpseq_dpath
  import lpseq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BA_W      = 2,
  parameter int INIT_WAIT = 10000,
  parameter int T_RP      = 2,
  parameter int T_RC      = 5,
  parameter int T_MRD     = 2,
  parameter int REF_COUNT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] modeVal,
  input  logic [ADDR_W-1:0] extModeVal,
  output logic              cntZero,
  output logic              refLast,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);

  localparam int MAX_A   = (INIT_WAIT > T_RC) ? INIT_WAIT : T_RC;
  localparam int MAX_B   = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAX_CNT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam int REF_W   = $clog2(REF_COUNT + 1);

  logic [CNT_W-1:0]  cnt, loadVal;
  logic [REF_W-1:0]  refCnt;
  logic [3:0]        strobeBits;
  logic [BA_W-1:0]   baNext;
  logic [ADDR_W-1:0] addrNext;

  // command waits count the issue cycle itself, hence the minus two
  always_comb begin
    unique case (stb.cntSel)
      WT_INIT: loadVal = CNT_W'(INIT_WAIT - 1);
      WT_RP:   loadVal = CNT_W'(T_RP - 2);
      WT_RC:   loadVal = CNT_W'(T_RC - 2);
      default: loadVal = CNT_W'(T_MRD - 2);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= CNT_W'(INIT_WAIT - 1);
    else if (stb.cntLoad)    cnt <= loadVal;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             refCnt <= '0;
    else if (stb.refClr)   refCnt <= '0;
    else if (stb.refInc)   refCnt <= refCnt + 1'b1;
  end
  assign refLast = (refCnt == REF_W'(REF_COUNT));

  // {csN, rasN, casN, weN} and address/bank for each command
  always_comb begin
    baNext   = '0;
    addrNext = '0;
    unique case (stb.cmd)
      CMD_DESEL: strobeBits = 4'b1111;
      CMD_PALL: begin
        strobeBits       = 4'b0010;
        addrNext[AP_BIT] = 1'b1;
      end
      CMD_AREF:  strobeBits = 4'b0001;
      CMD_MRS: begin
        strobeBits = 4'b0000;
        addrNext   = modeVal;
      end
      CMD_EMRS: begin
        strobeBits       = 4'b0000;
        addrNext         = extModeVal;
        baNext[BA_W-1]   = 1'b1;
      end
      CMD_DPD:   strobeBits = 4'b0110;
      default:   strobeBits = 4'b0111;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cke   <= 1'b1;
      csN   <= 1'b0;
      rasN  <= 1'b1;
      casN  <= 1'b1;
      weN   <= 1'b1;
      ba    <= '0;
      addr  <= '0;
      ready <= 1'b0;
    end else begin
      cke                      <= stb.ckeOn;
      {csN, rasN, casN, weN}   <= strobeBits;
      ba                       <= baNext;
      addr                     <= addrNext;
      ready                    <= stb.rdyOn;
    end
  end

endmodule

// File: rtl/lpsdram_pwr_seq.sv
module lpsdram_pwr_seq
  import lpseq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BA_W      = 2,
  parameter int INIT_WAIT = 10000,
  parameter int T_RP      = 2,
  parameter int T_RC      = 5,
  parameter int T_MRD     = 2,
  parameter int REF_COUNT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enterReq,
  input  logic              exitReq,
  input  logic              bankOpen,
  input  logic [ADDR_W-1:0] modeVal,
  input  logic [ADDR_W-1:0] extModeVal,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);

  strobe_t stb;
  logic    cntZero, refLast;

  lpseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enterReq (enterReq),
    .exitReq  (exitReq),
    .bankOpen (bankOpen),
    .cntZero  (cntZero),
    .refLast  (refLast),
    .stb      (stb)
  );

  lpseq_dpath #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .INIT_WAIT (INIT_WAIT),
    .T_RP      (T_RP),
    .T_RC      (T_RC),
    .T_MRD     (T_MRD),
    .REF_COUNT (REF_COUNT)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .modeVal    (modeVal),
    .extModeVal (extModeVal),
    .cntZero    (cntZero),
    .refLast    (refLast),
    .cke        (cke),
    .csN        (csN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .ba         (ba),
    .addr       (addr),
    .ready      (ready)
  );

endmodule

// File: rtl/lpseq_chk.sv
module lpseq_chk #(
  parameter int BA_W = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            cke,
  input logic            csN,
  input logic            rasN,
  input logic            casN,
  input logic            weN,
  input logic [BA_W-1:0] ba,
  input logic            apBit,
  input logic            ready
);

  logic isPall, isAref, isMode, isNop;
  assign isPall = cke && !csN && !rasN &&  casN && !weN;
  assign isAref = cke && !csN && !rasN && !casN &&  weN;
  assign isMode = cke && !csN && !rasN && !casN && !weN;
  assign isNop  = !csN && rasN && casN && weN;

  AST_PALL_AP_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    isPall |-> apBit); // R2

  AST_REF_BEFORE_READY: assert property (@(posedge clk) disable iff (!rstN)
    isAref |-> !ready); // R3

  AST_MODE_BANK: assert property (@(posedge clk) disable iff (!rstN)
    isMode |-> (ba[0] == 1'b0)); // R4

  AST_MODE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    isMode |=> (csN || (rasN && casN && weN))); // R4

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (cke && isNop)); // R5

  AST_DPD_ENCODE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |-> (!csN && rasN && casN && !weN && !ready)); // R6

  AST_DPD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cke && $past(!cke)) |-> csN); // R8

  AST_WAKE_NOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> (isNop && !ready)); // R9

endmodule

bind lpsdram_pwr_seq lpseq_chk #(.BA_W(BA_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .cke   (cke),
  .csN   (csN),
  .rasN  (rasN),
  .casN  (casN),
  .weN   (weN),
  .ba    (ba),
  .apBit (addr[lpseq_pkg::AP_BIT]),
  .ready (ready)
);

// File: tb/lpsdram_pwr_seq_bench.sv
module lpsdram_pwr_seq_bench;

  localparam int W    = 20;
  localparam int TRP  = 3;
  localparam int TRC  = 5;
  localparam int TMRD = 2;
  localparam int NREF = 8;

  localparam logic [5:0] WD_PALL  = 6'b100100;
  localparam logic [5:0] WD_AREF  = 6'b100010;
  localparam logic [5:0] WD_MODE  = 6'b100000;
  localparam logic [5:0] WD_RDY   = 6'b101111;
  localparam logic [5:0] WD_DPD   = 6'b001100;
  localparam logic [5:0] WD_WAKE  = 6'b101110;

  logic clk = 1'b0, rstN = 1'b0;
  logic enterReq = 1'b0, exitReq = 1'b0, bankOpen = 1'b0;
  logic [11:0] modeVal = 12'h032, extModeVal = 12'h041;
  logic cke, csN, rasN, casN, weN, ready;
  logic [1:0]  ba;
  logic [11:0] addr;

  int nChecks = 0, nFails = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int         at;
    logic [5:0] word;
    logic [1:0] ba;
    logic [11:0] addr;
    bit         chkAddr;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  lpsdram_pwr_seq #(
    .ADDR_W(12), .BA_W(2), .INIT_WAIT(W), .T_RP(TRP), .T_RC(TRC),
    .T_MRD(TMRD), .REF_COUNT(NREF)
  ) u_lpsdram_pwr_seq (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .exitReq(exitReq),
    .bankOpen(bankOpen), .modeVal(modeVal), .extModeVal(extModeVal),
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .ready(ready)
  );

  always #10 clk = ~clk;

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, string act, string expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%s expected=%s", tag, what, act, expv);
    end
  endtask

  task automatic push(int at, logic [5:0] word, logic [1:0] b, logic [11:0] a,
                      bit chkAddr, string tag);
    exp_t e;
    e.at = at; e.word = word; e.ba = b; e.addr = a; e.chkAddr = chkAddr; e.tag = tag;
    expQ.push_back(e);
  endtask

  // full initialization replay starting from the cycle clock enable is high
  task automatic pushInit(int base, output int rdyAt);
    int t;
    t = base + W;
    push(t, WD_PALL, 2'b00, 12'h400, 1'b1, "R2");
    t += TRP;
    push(t, WD_AREF, 2'b00, 12'h000, 1'b0, "R3");
    for (int i = 1; i < NREF; i++) begin
      t += TRC;
      push(t, WD_AREF, 2'b00, 12'h000, 1'b0, "R3");
    end
    t += TRC;
    push(t, WD_MODE, 2'b00, modeVal, 1'b1, "R4");
    t += TMRD;
    push(t, WD_MODE, 2'b10, extModeVal, 1'b1, "R4");
    t += TMRD;
    push(t, WD_RDY, 2'b00, 12'h000, 1'b0, "R5");
    rdyAt = t;
  endtask

  // monitor: every command, cke change and ready change is an event
  logic prevCke = 1'b1, prevRdy = 1'b0;
  always @(negedge clk) begin
    logic [5:0] word;
    bit isEv;
    exp_t e;
    word = {cke, csN, rasN, casN, weN, ready};
    isEv = (!csN && !(rasN && casN && weN)) || (cke != prevCke) || (ready != prevRdy);
    if (rstN && isEv) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R12", "unexpected pin event",
              $sformatf("cyc%0d/%b", cyc, word), "none");
      end else begin
        e = expQ.pop_front();
        check((word == e.word) && (cyc == e.at) &&
              (!e.chkAddr || ((addr == e.addr) && (ba == e.ba))),
              e.tag, "pin event",
              $sformatf("cyc%0d/%b/ba%b/a%h", cyc, word, ba, addr),
              $sformatf("cyc%0d/%b/ba%b/a%h", e.at, e.word, e.ba, e.addr));
      end
    end
    prevCke = cke;
    prevRdy = ready;
  end

  task automatic pulseEnter(output int c);
    @(negedge clk); enterReq = 1'b1; c = cyc;
    @(negedge clk); enterReq = 1'b0;
  endtask

  task automatic pulseExit(output int c);
    @(negedge clk); exitReq = 1'b1; c = cyc;
    @(negedge clk); exitReq = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int c, c2, rdyAt;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cke && !csN && rasN && casN && weN && !ready, "R1", "reset pins",
          $sformatf("%b", {cke, csN, rasN, casN, weN, ready}), "101110");
    pushInit(1, rdyAt);   // R1: NOP for W cycles, first command at W+1
    @(negedge clk); rstN = 1'b1;
    drain();

    // R12: exit request while ready is dropped
    pulseExit(c);
    repeat (10) @(negedge clk);
    check(ready && cke, "R12", "ready after stray exit",
          $sformatf("%b%b", ready, cke), "11");

    // R6: entry with no open bank
    pulseEnter(c);
    push(c + 3, WD_DPD, 2'b00, 12'h000, 1'b0, "R6");
    drain();
    repeat (5) @(negedge clk);
    check(!cke && csN, "R8", "held in deep power-down",
          $sformatf("cke%b cs%b", cke, csN), "cke0 cs1");

    // R12: entry request while in deep power-down is dropped
    pulseEnter(c);
    repeat (4) @(negedge clk);
    check(!cke && !ready, "R12", "stray entry in power-down",
          $sformatf("%b%b", cke, ready), "00");

    // R9 with new mode words (R4 uses the current values)
    modeVal = 12'h023; extModeVal = 12'h020;
    pulseExit(c);
    push(c + 3, WD_WAKE, 2'b00, 12'h000, 1'b0, "R9");
    pushInit(c + 3, rdyAt);
    drain();
    repeat (10) @(negedge clk);
    check(ready && expQ.size() == 0, "R12", "no re-entry after dropped request",
          $sformatf("%b", ready), "1");

    // R7 with R11: open bank, exit requested during pre-entry precharge
    bankOpen = 1'b1;
    pulseEnter(c);
    pulseExit(c2);
    push(c + 3, WD_PALL, 2'b00, 12'h400, 1'b1, "R7");
    push(c + 3 + TRP, WD_DPD, 2'b00, 12'h000, 1'b0, "R7");
    push(c + 5 + TRP, WD_WAKE, 2'b00, 12'h000, 1'b0, "R11");
    pushInit(c + 5 + TRP, rdyAt);
    while (!cke || cyc < c + 5 + TRP) @(negedge clk);
    bankOpen = 1'b0;

    // R10: entry request during initialization is held
    pulseEnter(c);
    push(rdyAt + 1, WD_DPD, 2'b00, 12'h000, 1'b0, "R10");
    drain();
    check(!cke && !ready, "R10", "in power-down after held entry",
          $sformatf("%b%b", cke, ready), "00");

    pulseExit(c);
    push(c + 3, WD_WAKE, 2'b00, 12'h000, 1'b0, "R9");
    pushInit(c + 3, rdyAt);
    drain();
    repeat (4) @(negedge clk);
    check(ready && cke, "R5", "ready after final init",
          $sformatf("%b%b", ready, cke), "11");
    check(expQ.size() == 0, "R5", "all expected events seen",
          $sformatf("%0d", expQ.size()), "0");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule